// File: doc/BRIEF.md
# Cell Modulation Index Solver

This block computes, once per switching period, a modulation index for every cell of a series chain of full-bridge cells. Its inputs are the sampled capacitor voltages, the arm current, the output voltage reference and the capacitor voltage reference. It applies a closed-form least-squares balancing law. Each index has two parts. The first is a share of the output reference weighted by that cell's voltage. The second is a balancing part, driven by the difference between the capacitor reference and the cell voltage scaled by the cluster-weighted sum. Because of this construction, the sum of cell voltage times index equals the output reference, apart from fixed-point truncation.

The law is evaluated as one fraction per cell, where S1 is the sum of the cell voltages, S2 is the sum of their squares and K is the parameter CAP_RATIO (the ratio of capacitance to switching period):

m_j = (vo·u_j·io + K·U·(S2 − u_j·S1)) / (io·S2)

When the arm current is zero, the balancing part is dropped and the index becomes m_j = vo·u_j / S2. The datapath works sequentially. A first pass accumulates S1 and S2 over the cells. A second pass runs one restoring division per cell. A one-cycle strobe then marks that all indexes are ready. The indexes are not clipped to ±1. Only the limits of the output format apply, and reaching them raises a flag.

Top module: `cell_index_solver`

## Requirements
- R1: After reset, every index output is 0, and done_o, busy_o and ovf_o are all low.
- R2: A start_i pulse while idle captures all inputs and raises busy_o. Later, done_o is high for exactly one cycle, and busy_o is low in that same cycle. The latency from start to done is the same for every input value.
- R3: For nonzero io_i, cell j's index equals (vo·u_j·io + CAP_RATIO·U·(S2 − u_j·S1))·2^FRAC / (io·S2), truncated toward zero. It is given as a signed MW-bit two's-complement value with FRAC fraction bits, and cell j occupies bits [j·MW +: MW] of m_o. Cell j's voltage occupies bits [j·VW +: VW] of uc_i.
- R4: When no index saturates, the sum over j of u_j·m_j differs from vo·2^FRAC by less than S1.
- R5: When io_i is 0, cell j's index equals vo·u_j·2^FRAC / S2, truncated toward zero.
- R6: When every cell voltage equals U, all indexes are equal to vo·2^FRAC/(N·U), truncated toward zero.
- R7: A result above 2^(MW−1)−1 or below −2^(MW−1) is clamped to that limit and sets ovf_o. The next start clears ovf_o.
- R8: When every cell voltage is 0, all indexes are 0 and ovf_o is set.
- R9: A start_i pulse while busy_o is high is ignored, and the run in progress completes with its original inputs.
- R10: Indexes beyond ±1.0 (±2^FRAC) are output unclipped.
- R11: Between the done strobe and the next accepted start, m_o and ovf_o hold their values even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a computation when idle |
| uc_i | input | N_CELLS·VW | Cell capacitor voltages, unsigned, cell j at [j·VW +: VW] |
| io_i | input | IW | Arm current, signed |
| vo_i | input | OW | Output voltage reference, signed |
| uref_i | input | VW | Capacitor voltage reference, unsigned |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle strobe when all indexes are valid |
| ovf_o | output | 1 | Saturation or degenerate input seen during the last run |
| m_o | output | N_CELLS·MW | Cell indexes, signed Q(MW−FRAC).FRAC, cell j at [j·MW +: MW] |

## Verification
On every cycle the assertions check the following:
- done_o is a one-cycle pulse that coincides with the end of busy_o.
- The outputs hold while the block is idle.
- The divider remainder stays below the divisor.
- The sum of squares never wraps while it accumulates.

The arithmetic itself can only be shown by the bench's scenarios. These scenarios compare each index with a value computed from the formula. They cover the balanced case, the unbalanced case with both signs of current, zero current, saturation in both directions, all-zero voltages, and a start issued while busy. They also check that the output reference is recovered from the weighted sum.

// File: rtl/cell_index_pkg.sv
package cell_index_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_LOAD,
    ST_DIV
  } solve_st_e;
endpackage

// File: rtl/cell_index_acc.sv
module cell_index_acc #(
  parameter int VW  = 8,
  parameter int S1W = 11,
  parameter int S2W = 19
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [VW-1:0]  u_i,
  output logic [S1W-1:0] s1_o,
  output logic [S2W-1:0] s2_o
);
  logic [S2W-1:0] u_w;
  assign u_w = S2W'(u_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_o <= '0;
      s2_o <= '0;
    end else if (clr_i) begin
      s1_o <= '0;
      s2_o <= '0;
    end else if (en_i) begin
      s1_o <= s1_o + S1W'(u_i);
      s2_o <= s2_o + u_w * u_w;
    end
  end

  // R3
  acc_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (s2_o >= $past(s2_o)));
endmodule

// File: rtl/cell_index_num.sv
module cell_index_num #(
  parameter int VW        = 8,
  parameter int IW        = 8,
  parameter int OW        = 12,
  parameter int S1W       = 11,
  parameter int S2W       = 19,
  parameter int NUMW      = 37,
  parameter int DENW      = 27,
  parameter int CAP_RATIO = 4
) (
  input  logic [VW-1:0]        u_i,
  input  logic [S1W-1:0]       s1_i,
  input  logic [S2W-1:0]       s2_i,
  input  logic signed [IW-1:0] io_i,
  input  logic signed [OW-1:0] vo_i,
  input  logic [VW-1:0]        uref_i,
  output logic [NUMW-1:0]      num_mag_o,
  output logic [DENW-1:0]      den_mag_o,
  output logic                 neg_o,
  output logic                 zero_den_o
);
  logic signed [NUMW-1:0] u_x, s1_x, s2_x, io_x, vo_x, ur_x, k_x;
  logic signed [NUMW-1:0] diff, term_a, term_b, num, den, den_abs;

  always_comb begin
    u_x  = NUMW'(u_i);
    s1_x = NUMW'(s1_i);
    s2_x = NUMW'(s2_i);
    ur_x = NUMW'(uref_i);
    io_x = NUMW'(io_i);
    vo_x = NUMW'(vo_i);
    k_x  = NUMW'(CAP_RATIO);
    diff   = s2_x - u_x * s1_x;
    term_a = vo_x * u_x * io_x;
    term_b = k_x * ur_x * diff;
    if (io_i == '0) begin
      num = vo_x * u_x;      // balancing term suppressed
      den = s2_x;
    end else begin
      num = term_a + term_b;
      den = io_x * s2_x;
    end
    neg_o      = num[NUMW-1] ^ den[NUMW-1];
    num_mag_o  = num[NUMW-1] ? NUMW'(-num) : NUMW'(num);
    den_abs    = den[NUMW-1] ? -den : den;
    den_mag_o  = DENW'(den_abs);
    zero_den_o = (s2_i == '0);
  end
endmodule

// File: rtl/cell_index_div.sv
module cell_index_div #(
  parameter int DW = 49,
  parameter int SW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [SW-1:0] dvs_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   q_q;
  logic [SW-1:0]   rem_q, dvs_q, rem_n;
  logic [CNTW-1:0] cnt_q;
  logic [SW:0]     sh, sub;
  logic            ge;

  always_comb begin
    sh    = {rem_q, q_q[DW-1]};
    sub   = sh - {1'b0, dvs_q};
    ge    = sh >= {1'b0, dvs_q};
    rem_n = ge ? sub[SW-1:0] : sh[SW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i && !busy_o) begin
      q_q    <= dvd_i;
      rem_q  <= '0;
      dvs_q  <= dvs_i;
      cnt_q  <= CNTW'(DW);
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      q_q   <= {q_q[DW-2:0], ge};
      rem_q <= rem_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = q_q;

  // R3
  div_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/cell_index_solver.sv
module cell_index_solver
  import cell_index_pkg::*;
#(
  parameter int N_CELLS   = 4,
  parameter int VW        = 8,
  parameter int IW        = 8,
  parameter int OW        = 12,
  parameter int KW        = 8,
  parameter int CAP_RATIO = 4,
  parameter int FRAC      = 12,
  parameter int MW        = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_CELLS*VW-1:0]   uc_i,
  input  logic signed [IW-1:0]    io_i,
  input  logic signed [OW-1:0]    vo_i,
  input  logic [VW-1:0]           uref_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    ovf_o,
  output logic [N_CELLS*MW-1:0]   m_o
);
  localparam int LGN  = $clog2(N_CELLS + 1);
  localparam int IDXW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
  localparam int S1W  = VW + LGN;
  localparam int S2W  = 2 * VW + LGN;
  localparam int A_W  = OW + VW + IW;
  localparam int B_W  = KW + VW + S2W + 1;
  localparam int NUMW = ((A_W > B_W) ? A_W : B_W) + 1;
  localparam int DENW = IW + S2W;
  localparam int DW   = NUMW + FRAC;
  localparam logic [DW-1:0] LIM_P = {{(DW-MW+1){1'b0}}, {(MW-1){1'b1}}};
  localparam logic [DW-1:0] LIM_N = LIM_P + 1'b1;
  localparam logic [IDXW-1:0] LAST = IDXW'(N_CELLS - 1);

  solve_st_e st_q;
  logic [VW-1:0]        uc_q [N_CELLS];
  logic signed [IW-1:0] io_q;
  logic signed [OW-1:0] vo_q;
  logic [VW-1:0]        uref_q;
  logic [IDXW-1:0]      idx_q;
  logic [MW-1:0]        m_q [N_CELLS];
  logic                 neg_q, zden_q;

  logic [S1W-1:0]  s1;
  logic [S2W-1:0]  s2;
  logic [NUMW-1:0] num_mag;
  logic [DENW-1:0] den_mag;
  logic            neg, zden;
  logic            div_busy, div_done;
  logic [DW-1:0]   quot;
  logic            accept;
  logic [MW-1:0]   res;
  logic            res_ovf;

  assign accept = start_i && (st_q == ST_IDLE);
  assign busy_o = (st_q != ST_IDLE);

  cell_index_acc #(.VW(VW), .S1W(S1W), .S2W(S2W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (st_q == ST_ACC),
    .u_i   (uc_q[idx_q]),
    .s1_o  (s1),
    .s2_o  (s2)
  );

  cell_index_num #(
    .VW(VW), .IW(IW), .OW(OW), .S1W(S1W), .S2W(S2W),
    .NUMW(NUMW), .DENW(DENW), .CAP_RATIO(CAP_RATIO)
  ) u_num (
    .u_i       (uc_q[idx_q]),
    .s1_i      (s1),
    .s2_i      (s2),
    .io_i      (io_q),
    .vo_i      (vo_q),
    .uref_i    (uref_q),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag),
    .neg_o     (neg),
    .zero_den_o(zden)
  );

  cell_index_div #(.DW(DW), .SW(DENW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(st_q == ST_LOAD),
    .dvd_i  ({num_mag, {FRAC{1'b0}}}),
    .dvs_i  (den_mag),
    .busy_o (div_busy),
    .done_o (div_done),
    .quot_o (quot)
  );

  // signed saturation of the unsigned quotient
  always_comb begin
    res_ovf = 1'b0;
    if (zden_q) begin
      res     = '0;
      res_ovf = 1'b1;
    end else if (!neg_q) begin
      if (quot > LIM_P) begin
        res     = LIM_P[MW-1:0];
        res_ovf = 1'b1;
      end else begin
        res = MW'(quot);
      end
    end else begin
      if (quot > LIM_N) begin
        res     = {1'b1, {(MW-1){1'b0}}};
        res_ovf = 1'b1;
      end else begin
        res = -MW'(quot);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      io_q   <= '0;
      vo_q   <= '0;
      uref_q <= '0;
      idx_q  <= '0;
      neg_q  <= 1'b0;
      zden_q <= 1'b0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
      for (int j = 0; j < N_CELLS; j++) begin
        uc_q[j] <= '0;
        m_q[j]  <= '0;
      end
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          for (int j = 0; j < N_CELLS; j++) uc_q[j] <= uc_i[j*VW +: VW];
          io_q   <= io_i;
          vo_q   <= vo_i;
          uref_q <= uref_i;
          idx_q  <= '0;
          ovf_o  <= 1'b0;
          st_q   <= ST_ACC;
        end
        ST_ACC: begin
          if (idx_q == LAST) begin
            idx_q <= '0;
            st_q  <= ST_LOAD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_LOAD: begin
          neg_q  <= neg;
          zden_q <= zden;
          st_q   <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          m_q[idx_q] <= res;
          ovf_o      <= ovf_o | res_ovf;
          if (idx_q == LAST) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_LOAD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_CELLS; g++) begin : g_out
    assign m_o[g*MW +: MW] = m_q[g];
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(m_o) && $stable(ovf_o)));
  // R9
  div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !div_busy);
endmodule

// File: tb/cell_index_solver_tb.sv
module cell_index_solver_tb;
  localparam int N    = 4;
  localparam int VW   = 8;
  localparam int IW   = 8;
  localparam int OW   = 12;
  localparam int K    = 4;
  localparam int FRAC = 12;
  localparam int MW   = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [N*VW-1:0] uc_i = '0;
  logic signed [IW-1:0] io_i = '0;
  logic signed [OW-1:0] vo_i = '0;
  logic [VW-1:0] uref_i = '0;
  logic busy_o, done_o, ovf_o;
  logic [N*MW-1:0] m_o;

  int n_tests = 0;
  int n_fail  = 0;
  int last_lat = 0;
  bit finished = 1'b0;

  longint u_t [N];
  longint io_t, vo_t, ur_t;

  always #2 clk = ~clk;

  cell_index_solver #(
    .N_CELLS(N), .VW(VW), .IW(IW), .OW(OW), .KW(8),
    .CAP_RATIO(K), .FRAC(FRAC), .MW(MW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .uc_i(uc_i),
    .io_i(io_i), .vo_i(vo_i), .uref_i(uref_i),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .m_o(m_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint m_at(input int j);
    return longint'($signed(m_o[j*MW +: MW]));
  endfunction

  function automatic longint exp_m(input int j, output bit sat);
    longint s1 = 0, s2 = 0, num, den, q;
    for (int i = 0; i < N; i++) begin
      s1 += u_t[i];
      s2 += u_t[i] * u_t[i];
    end
    sat = 1'b0;
    if (s2 == 0) begin
      sat = 1'b1;
      return 0;
    end
    if (io_t == 0) begin
      num = vo_t * u_t[j];
      den = s2;
    end else begin
      num = vo_t * u_t[j] * io_t + K * ur_t * (s2 - u_t[j] * s1);
      den = io_t * s2;
    end
    q = (num * (longint'(1) << FRAC)) / den;
    if (q > 32767) begin sat = 1'b1; q = 32767; end
    if (q < -32768) begin sat = 1'b1; q = -32768; end
    return q;
  endfunction

  task automatic drive(input longint a, input longint b, input longint c, input longint d,
                       input longint io, input longint vo, input longint ur);
    u_t[0] = a; u_t[1] = b; u_t[2] = c; u_t[3] = d;
    io_t = io; vo_t = vo; ur_t = ur;
    for (int j = 0; j < N; j++) uc_i[j*VW +: VW] = VW'(u_t[j]);
    io_i = IW'(io);
    vo_i = OW'(vo);
    uref_i = VW'(ur);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 1;
    while (!done_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o, req, cyc, 3000);
    last_lat = cyc;
  endtask

  task automatic check_all(input string req, output bit any_sat);
    bit s;
    longint e;
    any_sat = 1'b0;
    for (int j = 0; j < N; j++) begin
      e = exp_m(j, s);
      any_sat |= s;
      chk(m_at(j) == e, req, m_at(j), e);
    end
    chk(ovf_o == any_sat, {req, " ovf"}, longint'(ovf_o), longint'(any_sat));
  endtask

  task automatic run_case(input string req, output bit any_sat);
    pulse_start();
    wait_done("R2 done");
    check_all(req, any_sat);
  endtask

  task automatic t_reset();
    chk(m_o == '0, "R1 m_o", longint'(m_o[15:0]), 0);
    chk(!done_o && !busy_o && !ovf_o, "R1 flags",
        longint'({done_o, busy_o, ovf_o}), 0);
  endtask

  task automatic t_balanced();
    bit s;
    int l1;
    drive(64, 64, 64, 64, 16, 128, 64);
    run_case("R6", s);
    l1 = last_lat;
    for (int j = 0; j < N; j++)
      chk(m_at(j) == (128 * 4096) / (4 * 64), "R6 common", m_at(j), 2048);
    @(negedge clk);
    chk(!done_o, "R2 pulse width", longint'(done_o), 0);
    drive(60, 64, 68, 72, 16, 128, 64);
    run_case("R3 unbalanced", s);
    chk(last_lat == l1, "R2 latency", last_lat, l1);
  endtask

  task automatic t_sum_and_unclipped();
    bit s;
    longint acc = 0, s1 = 0, err, mx = 0;
    drive(60, 64, 68, 72, 16, 128, 64);
    run_case("R3", s);
    for (int j = 0; j < N; j++) begin
      acc += u_t[j] * m_at(j);
      s1  += u_t[j];
      if (m_at(j) > mx) mx = m_at(j);
    end
    err = acc - vo_t * 4096;
    if (err < 0) err = -err;
    chk(err < s1, "R4 weighted sum", acc, vo_t * 4096);
    chk(mx > 4096, "R10 unclipped", mx, 4096);
  endtask

  task automatic t_neg_current();
    bit s;
    drive(70, 50, 66, 58, -24, -300, 60);
    run_case("R3 negative io", s);
  endtask

  task automatic t_zero_current();
    bit s;
    drive(30, 90, 45, 80, 0, 500, 64);
    run_case("R5", s);
  endtask

  task automatic t_saturate();
    bit s;
    drive(1, 1, 1, 1, 1, 2047, 1);
    run_case("R7 positive", s);
    chk(ovf_o && m_at(0) == 32767, "R7 clamp max", m_at(0), 32767);
    drive(1, 1, 1, 1, 1, -2048, 1);
    run_case("R7 negative", s);
    chk(m_at(2) == -32768, "R7 clamp min", m_at(2), -32768);
    drive(64, 64, 64, 64, 16, 128, 64);
    run_case("R7 clear", s);
    chk(!ovf_o, "R7 ovf cleared", longint'(ovf_o), 0);
  endtask

  task automatic t_zero_volts();
    bit s;
    drive(0, 0, 0, 0, 10, 100, 64);
    run_case("R8", s);
    chk(ovf_o, "R8 ovf", longint'(ovf_o), 1);
  endtask

  task automatic t_start_busy();
    bit s;
    drive(55, 62, 70, 61, 20, 200, 62);
    pulse_start();
    repeat (10) @(negedge clk);
    uc_i = '0;
    vo_i = OW'(-1000);
    io_i = IW'(3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R9 done");
    check_all("R9", s);
  endtask

  task automatic t_hold();
    longint snap [N];
    bit o;
    for (int j = 0; j < N; j++) snap[j] = m_at(j);
    o = ovf_o;
    uc_i = '1;
    vo_i = OW'(777);
    io_i = IW'(-5);
    repeat (20) @(negedge clk);
    for (int j = 0; j < N; j++) chk(m_at(j) == snap[j], "R11 hold", m_at(j), snap[j]);
    chk(ovf_o == o && !busy_o, "R11 ovf hold", longint'(ovf_o), longint'(o));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_balanced();
    t_sum_and_unclipped();
    t_neg_current();
    t_zero_current();
    t_saturate();
    t_zero_volts();
    t_start_busy();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule